// File: doc/BRIEF.md
# 64-bit Bit-Manipulation Integer ALU

This block is a purely combinational integer ALU for a 64-bit datapath. Each cycle it takes two 64-bit operands and a 7-bit operation code and returns one 64-bit result. Beyond ordinary add, subtract, logic and shift work, it implements a bit-manipulation operation set. That set covers single-bit set, clear, invert and extract, rotates, shift-and-add address forms, adds on a zero-extended low word, inverted-operand logic, min/max, byte-wise OR-combine, sign extension, packing and byte reversal.

The three upper bits of the op code select an operation group, and the four low bits pick the operation inside that group. The block is meant to sit in an execute stage behind operand selection. It has no clock, and its result is valid in the same cycle as its inputs.

Top module: `bm_alu`

## Requirements
- R1: Op bits [6:4] choose the group (000 shift/bit, 001 word, 010 add, 011 subtract-based, 100 and 101 logic/extend/pack/reverse). Any op code not listed in R2 to R12, including groups 110 and 111, gives a result of zero.
- R2: Full-width shifts and rotates take their amount from src2[5:0]: 0000001 sll, 0000101 srl, 0000111 sra (arithmetic), 0001001 rotate left, 0001011 rotate right, and 0000000 shifts the zero-extended src1[31:0] left.
- R3: Op 0000010 clears, 0000011 sets and 0000100 inverts the src1 bit indexed by src2[5:0]. Op 0000110 returns that bit in result bit 0, with all other bits zero.
- R4: Word ops work on the low 32 bits, with shift amounts taken from src2[4:0], and sign-extend result bit 31 into bits 63:32: 0010000 add, 0010010 subtract, 0011000 shift left, 0011001 logical right, 0011010 arithmetic right, 0011100 rotate left, 0011101 rotate right.
- R5: Op 0100001 is src1+src2. Op 0100000 adds the zero-extended src1[31:0] to src2. Ops 0101001, 0101011 and 0101101 add src1 shifted left by 1, 2 and 3 to src2. Ops 0101000, 0101010 and 0101100 do the same on the zero-extended src1[31:0].
- R6: Op 0110000 gives src1-src2. Op 0110001 (unsigned) and op 0110010 (signed) give 1 when src1<src2 and 0 otherwise.
- R7: Op 0110100 is unsigned max, 0110101 unsigned min, 0110110 signed max and 0110111 signed min. The result is always one of the two operands.
- R8: Ops 1000000, 1000010 and 1000100 give AND, OR and XOR. Ops 1000001, 1000011 and 1000101 apply AND, OR and XOR to src1 and the bitwise inverse of src2.
- R9: Op 1000110 sets each result byte to 0xFF when the matching src1 byte is nonzero, and to 0x00 otherwise.
- R10: Op 1001000 sign-extends src1[7:0] and op 1001010 sign-extends src1[15:0] to 64 bits.
- R11: Op 1010010 gives {src2[31:0], src1[31:0]}. Op 1001001 gives src2[7:0] in bits 15:8 and src1[7:0] in bits 7:0, with zeros above. Op 1001011 sign-extends the 32-bit value {src2[15:0], src1[15:0]}.
- R12: Op 1010001 returns src1 with its eight bytes in reverse order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_i | input | 7 | Operation code, group in bits 6:4 |
| src1_i | input | 64 | First operand |
| src2_i | input | 64 | Second operand, bit index or shift amount |
| result_o | output | 64 | Combinational result |

## Verification
The block holds no state, so a fault in one unit's decode or in the group multiplexer shows up on result_o in the same cycle that the op and operands are applied. The faults most likely to slip past a sparse test are these: wrong width masks on the shift amount (5 bits against 6), a missing sign extension from bit 31, a wrong carry sense in the shared adder, and a mistaken compare polarity in min/max. The operand set therefore includes 0, all ones, the most negative value, the most positive value, and a value with bit 31 set and 63 in the low six bits. Every listed op runs against a reference model over all pairs of these values plus random values. Unlisted codes in every group are also applied to confirm that they return zero.

// File: rtl/bm_alu_pkg.sv
package bm_alu_pkg;

    localparam int unsigned DW  = 64;
    localparam int unsigned WW  = 32;
    localparam int unsigned OPW = 7;
    localparam int unsigned SW  = $clog2(DW);
    localparam int unsigned WSW = $clog2(WW);
    localparam int unsigned NB  = DW / 8;

    typedef enum logic [2:0] {
        GRP_SHIFT = 3'b000,
        GRP_WORD  = 3'b001,
        GRP_ADD   = 3'b010,
        GRP_SUB   = 3'b011,
        GRP_MISCA = 3'b100,
        GRP_MISCB = 3'b101
    } grp_e;

    typedef struct packed {
        logic          hit;
        logic [DW-1:0] val;
    } unit_res_t;

    function automatic logic [DW-1:0] sext_word(input logic [WW-1:0] w);
        return {{(DW-WW){w[WW-1]}}, w};
    endfunction

    function automatic logic [DW-1:0] zext_word(input logic [WW-1:0] w);
        return {{(DW-WW){1'b0}}, w};
    endfunction

endpackage

// File: rtl/bm_shift_unit.sv
module bm_shift_unit
    import bm_alu_pkg::*;
(
    input  logic [OPW-1:0] op,
    input  logic [DW-1:0]  a,
    input  logic [DW-1:0]  b,
    output unit_res_t      res
);
    logic [SW-1:0]   amt;
    logic [DW-1:0]   onehot;
    logic [2*DW-1:0] dbl_l;
    logic [2*DW-1:0] dbl_r;

    always_comb begin
        amt    = b[SW-1:0];
        onehot = {{(DW-1){1'b0}}, 1'b1} << amt;
        dbl_l  = {a, a} << amt;
        dbl_r  = {a, a} >> amt;
        res.hit = 1'b1;
        res.val = '0;
        case (op[3:0])
            4'b0000: res.val = zext_word(a[WW-1:0]) << amt;
            4'b0001: res.val = a << amt;
            4'b0010: res.val = a & ~onehot;
            4'b0011: res.val = a | onehot;
            4'b0100: res.val = a ^ onehot;
            4'b0101: res.val = a >> amt;
            4'b0110: res.val = {{(DW-1){1'b0}}, a[amt]};
            4'b0111: res.val = DW'($signed(a) >>> amt);
            4'b1001: res.val = dbl_l[2*DW-1:DW];
            4'b1011: res.val = dbl_r[DW-1:0];
            default: res.hit = 1'b0;
        endcase
        // R2: a rotate moves bits, it never creates or loses them
        if (op[3:0] == 4'b1001 || op[3:0] == 4'b1011)
            a_r2_rot_keeps_ones: assert ($countones(res.val) == $countones(a));
        // R3: single-bit ops touch at most one bit of src1
        if (op[3:0] == 4'b0010 || op[3:0] == 4'b0011 || op[3:0] == 4'b0100)
            a_r3_one_bit_touched: assert ($countones(res.val ^ a) <= 1);
    end
endmodule

// File: rtl/bm_word_unit.sv
module bm_word_unit
    import bm_alu_pkg::*;
(
    input  logic [OPW-1:0] op,
    input  logic [DW-1:0]  a,
    input  logic [DW-1:0]  b,
    output unit_res_t      res
);
    logic [WW-1:0]   aw;
    logic [WW-1:0]   bw;
    logic [WSW-1:0]  amt;
    logic [2*WW-1:0] dbl_l;
    logic [2*WW-1:0] dbl_r;
    logic [WW-1:0]   w;

    always_comb begin
        aw    = a[WW-1:0];
        bw    = b[WW-1:0];
        amt   = b[WSW-1:0];
        dbl_l = {aw, aw} << amt;
        dbl_r = {aw, aw} >> amt;
        res.hit = 1'b1;
        w = '0;
        case (op[3:0])
            4'b0000: w = aw + bw;
            4'b0010: w = aw - bw;
            4'b1000: w = aw << amt;
            4'b1001: w = aw >> amt;
            4'b1010: w = WW'($signed(aw) >>> amt);
            4'b1100: w = dbl_l[2*WW-1:WW];
            4'b1101: w = dbl_r[WW-1:0];
            default: res.hit = 1'b0;
        endcase
        res.val = res.hit ? sext_word(w) : '0;
        // R4: upper half always mirrors bit 31
        a_r4_upper_is_sign: assert (res.val[DW-1:WW] == {(DW-WW){res.val[WW-1]}});
        // R4: word rotate keeps the population of the low word
        if (op[3:0] == 4'b1100 || op[3:0] == 4'b1101)
            a_r4_rotw_keeps_ones: assert ($countones(res.val[WW-1:0]) == $countones(aw));
    end
endmodule

// File: rtl/bm_arith_unit.sv
module bm_arith_unit
    import bm_alu_pkg::*;
(
    input  logic [OPW-1:0] op,
    input  logic [DW-1:0]  a,
    input  logic [DW-1:0]  b,
    output unit_res_t      res
);
    logic          is_sub;
    logic [DW-1:0] base;
    logic [1:0]    pre_sh;
    logic          add_ok;
    logic [DW-1:0] opa;
    logic [DW-1:0] opb;
    logic [DW:0]   sum;
    logic          ltu;
    logic          lts;
    logic          lt_sel;
    logic          take_a;

    always_comb begin
        is_sub = op[4];
        base   = op[0] ? a : zext_word(a[WW-1:0]);
        pre_sh = op[3] ? (op[2:1] + 2'd1) : 2'd0;
        add_ok = op[3] ? (op[2:1] != 2'b11) : (op[2:1] == 2'b00);
        opa    = is_sub ? a : (base << pre_sh);
        opb    = is_sub ? ~b : b;
        sum    = {1'b0, opa} + {1'b0, opb} + {{DW{1'b0}}, is_sub};
        ltu    = ~sum[DW];
        lts    = (a[DW-1] ^ b[DW-1]) ? a[DW-1] : sum[DW-1];
        lt_sel = op[1] ? lts : ltu;
        take_a = (lt_sel == op[0]);
        res.hit = 1'b1;
        res.val = '0;
        if (!is_sub) begin
            res.hit = add_ok;
            res.val = add_ok ? sum[DW-1:0] : '0;
        end else begin
            case (op[3:0])
                4'b0000: res.val = sum[DW-1:0];
                4'b0001: res.val = {{(DW-1){1'b0}}, ltu};
                4'b0010: res.val = {{(DW-1){1'b0}}, lts};
                4'b0100, 4'b0101, 4'b0110, 4'b0111:
                         res.val = take_a ? a : b;
                default: res.hit = 1'b0;
            endcase
        end
        // R6: difference added back to src2 restores src1
        if (is_sub && op[3:0] == 4'b0000)
            a_r6_sub_inverse: assert (res.val + b == a);
        // R6: compare flags are 0 or 1
        if (is_sub && (op[3:0] == 4'b0001 || op[3:0] == 4'b0010))
            a_r6_flag_is_bit: assert (res.val[DW-1:1] == '0);
        // R7: min/max returns an operand, ordered correctly
        if (is_sub && op[3:2] == 2'b01) begin
            a_r7_pick_operand: assert (res.val == a || res.val == b);
            if (op[1:0] == 2'b01)
                a_r7_minu_order: assert (res.val <= a && res.val <= b);
            if (op[1:0] == 2'b00)
                a_r7_maxu_order: assert (res.val >= a && res.val >= b);
            if (op[1:0] == 2'b11)
                a_r7_min_order: assert ($signed(res.val) <= $signed(a) && $signed(res.val) <= $signed(b));
            if (op[1:0] == 2'b10)
                a_r7_max_order: assert ($signed(res.val) >= $signed(a) && $signed(res.val) >= $signed(b));
        end
    end
endmodule

// File: rtl/bm_misc_unit.sv
module bm_misc_unit
    import bm_alu_pkg::*;
(
    input  logic [OPW-1:0] op,
    input  logic [DW-1:0]  a,
    input  logic [DW-1:0]  b,
    output unit_res_t      res
);
    logic [4:0]    key;
    logic [DW-1:0] bx;
    logic [DW-1:0] orc;
    logic [DW-1:0] rev;

    for (genvar k = 0; k < NB; k++) begin : g_byte
        assign orc[8*k +: 8] = {8{|a[8*k +: 8]}};
        assign rev[8*k +: 8] = a[DW-8-8*k +: 8];
    end

    always_comb begin
        key = op[4:0];
        bx  = op[0] ? ~b : b;
        res.hit = 1'b1;
        res.val = '0;
        case (key)
            5'b00000, 5'b00001: res.val = a & bx;
            5'b00010, 5'b00011: res.val = a | bx;
            5'b00100, 5'b00101: res.val = a ^ bx;
            5'b00110:           res.val = orc;
            5'b01000:           res.val = {{(DW-8){a[7]}}, a[7:0]};
            5'b01001:           res.val = {{(DW-16){1'b0}}, b[7:0], a[7:0]};
            5'b01010:           res.val = {{(DW-16){a[15]}}, a[15:0]};
            5'b01011:           res.val = sext_word({b[15:0], a[15:0]});
            5'b10001:           res.val = rev;
            5'b10010:           res.val = {b[WW-1:0], a[WW-1:0]};
            default:            res.hit = 1'b0;
        endcase
        // R8: xnor is the complement of plain xor
        if (key == 5'b00101)
            a_r8_xnor_complement: assert ((res.val ^ a ^ b) == {DW{1'b1}});
        // R9: every byte saturates to all-zero or all-one
        if (key == 5'b00110)
            for (int k = 0; k < NB; k++)
                a_r9_orcb_byte: assert (res.val[8*k +: 8] == 8'h00 || res.val[8*k +: 8] == 8'hFF);
        // R12: outer bytes swap ends
        if (key == 5'b10001)
            a_r12_rev_ends: assert (res.val[7:0] == a[DW-1:DW-8] && res.val[DW-1:DW-8] == a[7:0]);
        // R10: byte extension replicates bit 7
        if (key == 5'b01000)
            a_r10_sextb_upper: assert ($countones(res.val[DW-1:7]) == 0 || res.val[DW-1:7] == {(DW-7){1'b1}});
    end
endmodule

// File: rtl/bm_alu.sv
module bm_alu
    import bm_alu_pkg::*;
(
    input  logic [6:0]  op_i,
    input  logic [63:0] src1_i,
    input  logic [63:0] src2_i,
    output logic [63:0] result_o
);
    grp_e      grp;
    unit_res_t r_shift;
    unit_res_t r_word;
    unit_res_t r_arith;
    unit_res_t r_misc;
    unit_res_t pick;

    assign grp = grp_e'(op_i[6:4]);

    bm_shift_unit u_shift (.op(op_i), .a(src1_i), .b(src2_i), .res(r_shift));
    bm_word_unit  u_word  (.op(op_i), .a(src1_i), .b(src2_i), .res(r_word));
    bm_arith_unit u_arith (.op(op_i), .a(src1_i), .b(src2_i), .res(r_arith));
    bm_misc_unit  u_misc  (.op(op_i), .a(src1_i), .b(src2_i), .res(r_misc));

    always_comb begin
        case (grp)
            GRP_SHIFT:            pick = r_shift;
            GRP_WORD:             pick = r_word;
            GRP_ADD, GRP_SUB:     pick = r_arith;
            GRP_MISCA, GRP_MISCB: pick = r_misc;
            default:              pick = '{hit: 1'b0, val: '0};
        endcase
        result_o = pick.hit ? pick.val : '0;
        // R1: the two unused groups never produce a nonzero value
        if (op_i[6:5] == 2'b11)
            a_r1_unused_group_zero: assert (result_o == '0);
    end
endmodule

// File: tb/sim_bm_alu.sv
module sim_bm_alu;
    localparam int CLK_PERIOD = 10;
    localparam int NOPS = 55;
    localparam int NCORNER = 6;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [6:0]  op;
    logic [63:0] s1;
    logic [63:0] s2;
    logic [63:0] res;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    typedef struct {
        logic [6:0]  op;
        logic [63:0] a;
        logic [63:0] b;
        logic [63:0] exp;
    } item_t;
    item_t sbq[$];

    localparam logic [6:0] OPS [0:NOPS-1] = '{
        7'b0000000, 7'b0000001, 7'b0000010, 7'b0000011, 7'b0000100,
        7'b0000101, 7'b0000110, 7'b0000111, 7'b0001001, 7'b0001011,
        7'b0010000, 7'b0010010, 7'b0011000, 7'b0011001, 7'b0011010,
        7'b0011100, 7'b0011101,
        7'b0100000, 7'b0100001, 7'b0101000, 7'b0101001, 7'b0101010,
        7'b0101011, 7'b0101100, 7'b0101101,
        7'b0110000, 7'b0110001, 7'b0110010, 7'b0110100, 7'b0110101,
        7'b0110110, 7'b0110111,
        7'b1000000, 7'b1000001, 7'b1000010, 7'b1000011, 7'b1000100,
        7'b1000101, 7'b1000110,
        7'b1001000, 7'b1001001, 7'b1001010, 7'b1001011, 7'b1010001,
        7'b1010010,
        7'b0001000, 7'b0001010, 7'b0010001, 7'b0100010, 7'b0101111,
        7'b0110011, 7'b1000111, 7'b1010000, 7'b1100000, 7'b1111111
    };

    localparam logic [63:0] CORNER [0:NCORNER-1] = '{
        64'h0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h8000_0000_0000_0000,
        64'h7FFF_FFFF_FFFF_FFFF, 64'h0000_0000_8000_003F, 64'h1
    };

    bm_alu u0 (.op_i(op), .src1_i(s1), .src2_i(s2), .result_o(res));

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [63:0] sx32(input logic [31:0] w);
        return {{32{w[31]}}, w};
    endfunction

    function automatic logic [31:0] rot32(input logic [31:0] w, input int n, input bit left);
        if (n == 0) return w;
        return left ? ((w << n) | (w >> (32 - n))) : ((w >> n) | (w << (32 - n)));
    endfunction

    function automatic logic [63:0] model(input logic [6:0] o, input logic [63:0] a, input logic [63:0] b);
        logic [63:0] r;
        logic [63:0] az;
        int n6;
        int n5;
        n6 = int'(b[5:0]);
        n5 = int'(b[4:0]);
        az = {32'h0, a[31:0]};
        r = 64'h0;
        case (o)
            7'b0000000: r = az << n6;
            7'b0000001: r = a << n6;
            7'b0000010: begin r = a; r[n6] = 1'b0; end
            7'b0000011: begin r = a; r[n6] = 1'b1; end
            7'b0000100: begin r = a; r[n6] = ~a[n6]; end
            7'b0000101: r = a >> n6;
            7'b0000110: r = {63'h0, a[n6]};
            7'b0000111: r = $signed(a) >>> n6;
            7'b0001001: r = (n6 == 0) ? a : ((a << n6) | (a >> (64 - n6)));
            7'b0001011: r = (n6 == 0) ? a : ((a >> n6) | (a << (64 - n6)));
            7'b0010000: r = sx32(a[31:0] + b[31:0]);
            7'b0010010: r = sx32(a[31:0] - b[31:0]);
            7'b0011000: r = sx32(a[31:0] << n5);
            7'b0011001: r = sx32(a[31:0] >> n5);
            7'b0011010: r = sx32($signed(a[31:0]) >>> n5);
            7'b0011100: r = sx32(rot32(a[31:0], n5, 1'b1));
            7'b0011101: r = sx32(rot32(a[31:0], n5, 1'b0));
            7'b0100000: r = az + b;
            7'b0100001: r = a + b;
            7'b0101000: r = (az << 1) + b;
            7'b0101001: r = (a << 1) + b;
            7'b0101010: r = (az << 2) + b;
            7'b0101011: r = (a << 2) + b;
            7'b0101100: r = (az << 3) + b;
            7'b0101101: r = (a << 3) + b;
            7'b0110000: r = a - b;
            7'b0110001: r = (a < b) ? 64'd1 : 64'd0;
            7'b0110010: r = ($signed(a) < $signed(b)) ? 64'd1 : 64'd0;
            7'b0110100: r = (a > b) ? a : b;
            7'b0110101: r = (a < b) ? a : b;
            7'b0110110: r = ($signed(a) > $signed(b)) ? a : b;
            7'b0110111: r = ($signed(a) < $signed(b)) ? a : b;
            7'b1000000: r = a & b;
            7'b1000001: r = a & ~b;
            7'b1000010: r = a | b;
            7'b1000011: r = a | ~b;
            7'b1000100: r = a ^ b;
            7'b1000101: r = ~(a ^ b);
            7'b1000110: for (int k = 0; k < 8; k++) r[8*k +: 8] = (a[8*k +: 8] != 8'h0) ? 8'hFF : 8'h00;
            7'b1001000: r = {{56{a[7]}}, a[7:0]};
            7'b1001001: r = {48'h0, b[7:0], a[7:0]};
            7'b1001010: r = {{48{a[15]}}, a[15:0]};
            7'b1001011: r = sx32({b[15:0], a[15:0]});
            7'b1010001: for (int k = 0; k < 8; k++) r[8*k +: 8] = a[8*(7-k) +: 8];
            7'b1010010: r = {b[31:0], a[31:0]};
            default:    r = 64'h0;
        endcase
        return r;
    endfunction

    function automatic string tag(input logic [6:0] o);
        case (o)
            7'b0000000, 7'b0000001, 7'b0000101, 7'b0000111,
            7'b0001001, 7'b0001011:                         return "R2";
            7'b0000010, 7'b0000011, 7'b0000100, 7'b0000110: return "R3";
            7'b0010000, 7'b0010010, 7'b0011000, 7'b0011001,
            7'b0011010, 7'b0011100, 7'b0011101:             return "R4";
            7'b0100000, 7'b0100001, 7'b0101000, 7'b0101001,
            7'b0101010, 7'b0101011, 7'b0101100, 7'b0101101: return "R5";
            7'b0110000, 7'b0110001, 7'b0110010:             return "R6";
            7'b0110100, 7'b0110101, 7'b0110110, 7'b0110111: return "R7";
            7'b1000000, 7'b1000001, 7'b1000010, 7'b1000011,
            7'b1000100, 7'b1000101:                         return "R8";
            7'b1000110:                                     return "R9";
            7'b1001000, 7'b1001010:                         return "R10";
            7'b1001001, 7'b1001011, 7'b1010010:             return "R11";
            7'b1010001:                                     return "R12";
            default:                                        return "R1";
        endcase
    endfunction

    task automatic drive(input logic [6:0] o, input logic [63:0] a, input logic [63:0] b);
        item_t it;
        @(negedge clk);
        op = o;
        s1 = a;
        s2 = b;
        it.op = o;
        it.a = a;
        it.b = b;
        it.exp = model(o, a, b);
        sbq.push_back(it);
    endtask

    // monitor: result settles half a period after the inputs change
    always @(posedge clk) begin
        item_t it;
        if (sbq.size() > 0) begin
            it = sbq.pop_front();
            checks++;
            if (res !== it.exp) begin
                errors++;
                $display("FAIL %s op=%b a=%h b=%h actual=%h expected=%h",
                         tag(it.op), it.op, it.a, it.b, res, it.exp);
            end
        end
    end

    initial begin
        op = 7'h0;
        s1 = 64'h0;
        s2 = 64'h0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: reset-time state with idle operands yields zero
        drive(7'h0, 64'h0, 64'h0);
        // every op, known and unknown, over corner operand pairs
        for (int i = 0; i < NOPS; i++)
            for (int j = 0; j < NCORNER; j++)
                for (int k = 0; k < NCORNER; k++)
                    drive(OPS[i], CORNER[j], CORNER[k]);
        // random operands, including random shift amounts and bit indices
        for (int i = 0; i < NOPS; i++)
            for (int r = 0; r < 16; r++)
                drive(OPS[i], {$urandom(), $urandom()}, {$urandom(), $urandom()});
        // R3: bit index ignores src2 bits above [5:0]
        drive(7'b0000011, 64'h0, 64'hFFFF_FFFF_FFFF_FF05);
        // R4: word shift ignores src2 bit 5
        drive(7'b0011000, 64'h0000_0000_0000_0001, 64'h0000_0000_0000_0021);
        repeat (3) @(negedge clk);
        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!finished) begin
            finished = 1'b1;
            errors++;
            checks++;
            $display("FAIL watchdog R1 actual=hung expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule